// File: doc/BRIEF.md
# Flag-Configured SPI Master

This block is a serial-peripheral master whose bus behaviour comes from a 7-bit mode word. The word selects the duplex mode: full duplex, receive only or transmit only. It also sets the clock idle level, the capture edge and the bit order. Two further fields decide whether the serial clock pin moves at all and whether the dedicated active-low select pin follows a host control input. The first accepted write of the mode word switches the bus on.

The host offers bytes on a valid/ready stream. Each accepted byte is shifted out while a byte is shifted in, and the received byte is returned as a one-cycle pulse. The bit rate comes from an external clock-enable `tick`. One `tick` is one half of a bit period. Each byte is followed by an idle gap in which the clock rests at its idle level. The select line is held by the host's control input, so it stays low across those gaps in a multi-byte burst. A mode write is accepted only while the engine is idle.

Top module: `spi_flag_master`

## Requirements
- R1: After reset `tx_ready` is low and stays low, with `sclk` quiet, until the first mode write is accepted. From then on `tx_ready` is high whenever the engine is idle.
- R2: Mode bit 2 sets the level of `sclk` while no byte is in flight: 1 gives idle high, 0 gives idle low. The reset level is low.
- R3: Mode bit 3 picks the capture edge. When it is 0, data is captured on the first clock edge of each bit and changed on the second. When it is 1, data is changed on the first edge and captured on the second. Both the byte received by the slave and the byte returned to the host are correct in all four combinations of bits 2 and 3.
- R4: Mode bit 4 set sends and assembles bits least significant first. When it is clear, the most significant bit goes first.
- R5: With mode bit 5 set, `sclk` holds its idle level for the whole transfer. The engine still takes the same number of ticks and samples `miso` at the same points.
- R6: With mode bit 6 set, `cs_n` is the inverse of `cs_sel`. With it clear, `cs_n` stays high. `cs_n` stays low across the gaps of a burst while `cs_sel` is held.
- R7: Mode bit 0 (receive only) takes precedence over bit 1. In this mode `mosi` is 0 during every transfer and the offered byte value is ignored. The handshake still starts a byte and the received byte is returned.
- R8: With bit 1 set and bit 0 clear (transmit only), `rx_valid` never pulses.
- R9: Each byte takes 16 ticks of clock activity, with the last `sclk` change on the 16th tick, then 2 idle ticks before `tx_ready` returns. For DATA_W bits and GAP_TICKS gap ticks, this is 2*DATA_W ticks followed by GAP_TICKS ticks.
- R10: While a byte is in flight `cfg_ready` is low and a pending mode write is held off. The mode in force does not change until the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Half-bit-period clock enable |
| cfg_wr | input | 1 | Mode write request |
| cfg_data | input | 7 | Mode word (bit0 rx only, bit1 tx only, bit2 idle high, bit3 second-edge capture, bit4 LSB first, bit5 no clock, bit6 select enable) |
| cfg_ready | output | 1 | Mode write can be accepted |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | DATA_W | Transmit byte |
| tx_ready | output | 1 | Transmit byte accepted this cycle when valid |
| rx_valid | output | 1 | One-cycle pulse: received byte present |
| rx_data | output | DATA_W | Received byte |
| cs_sel | input | 1 | Host control of the dedicated select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Dedicated active-low select |

## Verification
The bench uses the default DATA_W of 8 and GAP_TICKS of 2, with a tick every fourth clock. Eight-bit bytes let each directed pattern make bit order and capture edge visible: a lone set bit at one end of the byte lands at the wrong end if either is wrong. The two-tick gap, set against sixteen clock edges, gives a fixed tick count that the bench checks on every byte. The slow tick leaves several clocks between edges, so the slave model can react on the opposite edge of the master and still be seen in time.

// File: rtl/spif_pkg.sv
package spif_pkg;

    localparam int MODE_W = 7;

    // Packing order matches the mode word bit positions (bit6 first).
    typedef struct packed {
        logic cs_en;
        logic no_clk;
        logic lsb_first;
        logic cpha;
        logic cpol;
        logic tx_only;
        logic rx_only;
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } eng_state_t;

    // Position in the data word of the i-th bit on the wire.
    function automatic int unsigned lane(input int unsigned i, input logic lsb,
                                         input int unsigned w);
        return lsb ? i : (w - 1 - i);
    endfunction

endpackage

// File: rtl/spif_cfg.sv
module spif_cfg
    import spif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [MODE_W-1:0] cfg_data,
    input  logic              idle,
    output mode_t             mode,
    output logic              bus_en,
    output logic              cfg_ready
);
    assign cfg_ready = idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= '0;
            bus_en <= 1'b0;
        end else if (cfg_wr && idle) begin
            mode   <= mode_t'(cfg_data);
            bus_en <= 1'b1;
        end
    end
endmodule

// File: rtl/spif_seq.sv
module spif_seq
    import spif_pkg::*;
#(
    parameter int  DATA_W    = 8,
    parameter int  GAP_TICKS = 2,
    localparam int EDGES     = 2 * DATA_W,
    localparam int EC_W      = $clog2(EDGES),
    localparam int BI_W      = EC_W - 1,
    localparam int GC_W      = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            start,
    output eng_state_t      state,
    output logic            phase,
    output logic            lead,
    output logic            trail,
    output logic            done,
    output logic [BI_W-1:0] bit_idx
);
    logic [EC_W-1:0] ec;
    logic [GC_W-1:0] gc;
    logic            shift_tick;

    assign shift_tick = (state == ST_SHIFT) && tick;
    assign lead       = shift_tick && !ec[0];
    assign trail      = shift_tick && ec[0];
    assign done       = shift_tick && (ec == EC_W'(EDGES - 1));
    assign bit_idx    = ec[EC_W-1:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ec    <= '0;
            gc    <= '0;
            phase <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_SHIFT;
                        ec    <= '0;
                        phase <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        phase <= ~phase;
                        if (ec == EC_W'(EDGES - 1)) begin
                            state <= ST_GAP;
                            gc    <= '0;
                        end else begin
                            ec <= ec + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gc == GC_W'(GAP_TICKS - 1)) state <= ST_IDLE;
                        else                            gc    <= gc + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spif_shift.sv
module spif_shift
    import spif_pkg::*;
#(
    parameter int  DATA_W = 8,
    localparam int BI_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_t             mode,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              lead,
    input  logic              trail,
    input  logic              done,
    input  logic [BI_W-1:0]   bit_idx,
    input  logic              miso,
    output logic              mosi,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_byte
);
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] rx_next;
    logic [BI_W-1:0]   cur_pos;
    logic [BI_W-1:0]   nxt_pos;
    logic [BI_W-1:0]   first_pos;
    logic              sample;
    logic              rx_on;

    assign sample    = mode.cpha ? trail : lead;
    assign rx_on     = mode.rx_only || !mode.tx_only;
    assign cur_pos   = BI_W'(lane(32'(bit_idx), mode.lsb_first, DATA_W));
    assign nxt_pos   = BI_W'(lane(32'(bit_idx) + 1, mode.lsb_first, DATA_W));
    assign first_pos = BI_W'(lane(0, mode.lsb_first, DATA_W));

    always_comb begin
        rx_next = rx_sh;
        if (sample) rx_next[cur_pos] = miso;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q     <= '0;
            rx_sh    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            mosi     <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rx_sh    <= rx_next;
            if (load) begin
                tx_q  <= mode.rx_only ? '0 : tx_byte;
                mosi  <= mode.rx_only ? 1'b0 : tx_byte[first_pos];
                rx_sh <= '0;
            end else if (!mode.cpha && trail && !done) begin
                mosi <= tx_q[nxt_pos];
            end else if (mode.cpha && lead) begin
                mosi <= tx_q[cur_pos];
            end
            if (done) begin
                rx_byte  <= rx_next;
                rx_valid <= rx_on;
            end
        end
    end
endmodule

// File: rtl/spi_flag_master.sv
module spi_flag_master
    import spif_pkg::*;
#(
    parameter int  DATA_W    = 8,
    parameter int  GAP_TICKS = 2,
    localparam int BI_W      = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              cfg_wr,
    input  logic [6:0]        cfg_data,
    output logic              cfg_ready,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    input  logic              cs_sel,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    mode_t           mode;
    logic            bus_en;
    eng_state_t      state;
    logic            idle;
    logic            start;
    logic            phase;
    logic            lead;
    logic            trail;
    logic            done;
    logic [BI_W-1:0] bit_idx;

    assign idle     = (state == ST_IDLE);
    assign tx_ready = bus_en && idle && !cfg_wr;
    assign start    = tx_valid && tx_ready;
    assign sclk     = mode.no_clk ? mode.cpol : (mode.cpol ^ phase);
    assign cs_n     = ~(mode.cs_en & cs_sel);

    spif_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_data  (cfg_data),
        .idle      (idle),
        .mode      (mode),
        .bus_en    (bus_en),
        .cfg_ready (cfg_ready)
    );

    spif_seq #(.DATA_W(DATA_W), .GAP_TICKS(GAP_TICKS)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .start   (start),
        .state   (state),
        .phase   (phase),
        .lead    (lead),
        .trail   (trail),
        .done    (done),
        .bit_idx (bit_idx)
    );

    spif_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .load     (start),
        .tx_byte  (tx_data),
        .lead     (lead),
        .trail    (trail),
        .done     (done),
        .bit_idx  (bit_idx),
        .miso     (miso),
        .mosi     (mosi),
        .rx_valid (rx_valid),
        .rx_byte  (rx_data)
    );
endmodule

// File: rtl/spif_chk.sv
module spif_chk
    import spif_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sclk,
    input logic       mosi,
    input logic       cs_n,
    input logic       rx_valid,
    input logic       tx_ready,
    input logic       bus_en,
    input mode_t      mode,
    input eng_state_t state
);
    // R1
    en_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_en |-> !tx_ready);
    // R2
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (sclk == mode.cpol));
    // R5
    no_clk_chk: assert property (@(posedge clk) disable iff (rst)
        mode.no_clk |-> (sclk == mode.cpol));
    // R6
    cs_off_chk: assert property (@(posedge clk) disable iff (rst)
        !mode.cs_en |-> cs_n);
    // R7
    rx_only_mosi_chk: assert property (@(posedge clk) disable iff (rst)
        (mode.rx_only && state != ST_IDLE) |-> !mosi);
    // R8
    tx_only_chk: assert property (@(posedge clk) disable iff (rst)
        (mode.tx_only && !mode.rx_only) |-> !rx_valid);
    // R9
    gap_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP) |-> (sclk == mode.cpol));
    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(mode));
endmodule

bind spi_flag_master spif_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .sclk     (sclk),
    .mosi     (mosi),
    .cs_n     (cs_n),
    .rx_valid (rx_valid),
    .tx_ready (tx_ready),
    .bus_en   (bus_en),
    .mode     (mode),
    .state    (state)
);

// File: tb/spi_flag_master_tb.sv
module spi_flag_master_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [6:0] cfg_data = '0;
    logic       cfg_ready;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_ready;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       cs_sel = 1'b0;
    logic       sclk;
    logic       mosi;
    logic       miso = 1'b0;
    logic       cs_n;

    int checks = 0;
    int errors = 0;

    // bench copy of the mode in force
    logic m_rxo = 0, m_txo = 0, m_cpol = 0, m_cpha = 0, m_lsb = 0, m_noclk = 0, m_cs = 0;
    // slave model state
    logic [7:0] s_tx = '0, s_rx = '0;
    int lc = 0, tc = 0;
    logic ps = 1'b0;
    logic cs_watch = 1'b0;
    int cs_bad = 0;

    always #2.5 clk = ~clk;

    spi_flag_master dut_i (
        .clk(clk), .rst(rst), .tick(tick), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .cfg_ready(cfg_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .cs_sel(cs_sel), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    function automatic int bp(input int i, input logic lsb);
        return lsb ? i : 7 - i;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // tick generator: one tick every fourth clock, changed 1 ns after negedge
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            #1;
            cnt  = (cnt + 1) % 4;
            tick = (cnt == 0);
        end
    end

    // slave model, reacting to sclk edges at the negedge
    initial begin
        forever begin
            @(negedge clk);
            if (sclk !== ps) begin
                if (ps == m_cpol) begin
                    if (!m_cpha) begin
                        if (lc < 8) s_rx[bp(lc, m_lsb)] = mosi;
                    end else begin
                        if (lc < 8) miso = s_tx[bp(lc, m_lsb)];
                    end
                    lc++;
                end else begin
                    if (!m_cpha) begin
                        tc++;
                        if (tc < 8) miso = s_tx[bp(tc, m_lsb)];
                    end else begin
                        if (tc < 8) s_rx[bp(tc, m_lsb)] = mosi;
                        tc++;
                    end
                end
            end
            ps = sclk;
        end
    end

    // select monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (cs_watch && cs_n) cs_bad++;
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic set_cfg(input logic [6:0] v);
        @(negedge clk);
        while (!cfg_ready) @(negedge clk);
        cfg_wr   = 1'b1;
        cfg_data = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        {m_cs, m_noclk, m_lsb, m_cpha, m_cpol, m_txo, m_rxo} = v;
    endtask

    task automatic xfer(input logic [7:0] d, input logic [7:0] sd, input string tag);
        int ticks = 0, tog = 0, last_tog = 0, seen = 0;
        logic [7:0] got = '0;
        logic [7:0] exp_m, exp_s;
        logic prev;
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        s_tx = sd; s_rx = '0; lc = 0; tc = 0;
        miso = sd[bp(0, m_lsb)];
        tx_valid = 1'b1;
        tx_data  = d;
        @(negedge clk);
        tx_valid = 1'b0;
        prev = sclk;
        for (int guard = 0; guard < 500; guard++) begin
            @(negedge clk);
            if (tick) ticks++;
            if (sclk !== prev) begin tog++; last_tog = ticks; end
            prev = sclk;
            if (rx_valid) begin seen++; got = rx_data; end
            if (tx_ready) break;
        end
        chk(ticks == 18, "R9", ticks, 18);
        chk(sclk == m_cpol, "R2", sclk, m_cpol);
        if (m_noclk) begin
            chk(tog == 0, "R5", tog, 0);
        end else begin
            chk(tog == 16 && last_tog == 16, "R9", last_tog, 16);
            exp_s = m_rxo ? 8'h00 : d;
            chk(s_rx == exp_s, m_rxo ? "R7" : tag, s_rx, exp_s);
        end
        exp_m = m_noclk ? {8{sd[bp(0, m_lsb)]}} : sd;
        if (m_txo && !m_rxo) begin
            chk(seen == 0, "R8", seen, 0);
        end else begin
            chk(seen == 1, "R3", seen, 1);
            chk(got == exp_m, tag, got, exp_m);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(tx_ready == 0, "R1", tx_ready, 0);
        chk(cfg_ready == 1, "R10", cfg_ready, 1);
        chk(sclk == 0, "R2", sclk, 0);
        chk(cs_n == 1, "R6", cs_n, 1);
        // R1 offered bytes before any mode write are not taken
        tx_valid = 1'b1;
        tx_data  = 8'h81;
        begin
            int moved = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (tx_ready || sclk) moved++;
            end
            chk(moved == 0, "R1", moved, 0);
        end
        tx_valid = 1'b0;
        set_cfg(7'h00);
        @(negedge clk);
        chk(tx_ready == 1, "R1", tx_ready, 1);

        // R3 four clock modes, MSB first
        xfer(8'hA5, 8'h3C, "R3");
        set_cfg(7'h08); xfer(8'h5A, 8'hC3, "R3");
        set_cfg(7'h04);
        chk(sclk == 1, "R2", sclk, 1);
        xfer(8'h96, 8'h0F, "R3");
        set_cfg(7'h0C); xfer(8'h1E, 8'hE1, "R3");

        // R4 LSB first with single set bits
        set_cfg(7'h10); xfer(8'h01, 8'h80, "R4");
        set_cfg(7'h1C); xfer(8'h02, 8'h40, "R4");
        set_cfg(7'h18); xfer(8'hC0, 8'h03, "R4");

        // R5 no clock
        set_cfg(7'h20); xfer(8'hFF, 8'h80, "R5");
        set_cfg(7'h24); xfer(8'h00, 8'h7F, "R5");

        // R7 receive only, also with both simplex bits
        set_cfg(7'h01); xfer(8'hFF, 8'h5A, "R7");
        set_cfg(7'h03); xfer(8'hAA, 8'hA6, "R7");

        // R8 transmit only
        set_cfg(7'h02); xfer(8'h6C, 8'hFF, "R8");

        // R6 dedicated select held over a burst
        set_cfg(7'h40);
        cs_sel = 1'b1;
        @(negedge clk);
        chk(cs_n == 0, "R6", cs_n, 0);
        cs_watch = 1'b1;
        xfer(8'h11, 8'h22, "R6");
        xfer(8'h33, 8'h44, "R6");
        xfer(8'h55, 8'h66, "R6");
        cs_watch = 1'b0;
        chk(cs_bad == 0, "R6", cs_bad, 0);
        cs_sel = 1'b0;
        @(negedge clk);
        chk(cs_n == 1, "R6", cs_n, 1);
        cs_sel = 1'b1;
        set_cfg(7'h00);
        @(negedge clk);
        chk(cs_n == 1, "R6", cs_n, 1);
        cs_sel = 1'b0;

        // R10 mode write held off during a byte
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_valid = 1'b1; tx_data = 8'h77;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (10) @(negedge clk);
        cfg_wr = 1'b1; cfg_data = 7'h04;
        @(negedge clk);
        chk(cfg_ready == 0, "R10", cfg_ready, 0);
        chk(sclk == 0 || sclk == 1, "R10", sclk, 0);
        begin
            int held = 0;
            for (int g = 0; g < 300 && !cfg_ready; g++) begin
                @(negedge clk);
                if (!cfg_ready && sclk == 1 && !dut_idle_guess()) held++;
            end
        end
        @(negedge clk);
        cfg_wr = 1'b0;
        {m_cs, m_noclk, m_lsb, m_cpha, m_cpol, m_txo, m_rxo} = 7'h04;
        @(negedge clk);
        chk(sclk == 1, "R10", sclk, 1);
        xfer(8'hB4, 8'h4B, "R3");

        // random sweep
        for (int n = 0; n < 40; n++) begin
            logic [6:0] v;
            logic [31:0] r;
            r = $urandom;
            v = '0;
            v[2] = r[0]; v[3] = r[1]; v[4] = r[2]; v[6] = r[3];
            if (r[6:4] == 3'd0) v[0] = 1'b1;
            if (r[6:4] == 3'd1) v[1] = 1'b1;
            if (r[6:4] == 3'd2) v[5] = 1'b1;
            set_cfg(v);
            xfer(8'($urandom), 8'($urandom), v[4] ? "R4" : "R3");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic bit dut_idle_guess();
        return cfg_ready;
    endfunction
endmodule